// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits between an instruction fetch queue and the execution pipes of a two-way superscalar front end. It holds a two-entry issue window: an older slot and a younger slot. Each cycle it decides whether the older instruction issues alone, whether the two issue together, or whether nothing issues because a multi-step instruction still holds the issue stage. The decision depends on each instruction's execution group, on register dependencies between the two, on a resource-lock flag and on a step count.

When only the older instruction issues, the younger one is not dropped. It moves into the older slot and is paired with the next fetched instruction on the following cycle. The block tells fetch how many instructions it took each cycle through `fetch_pop`, so the fetch queue can present its two oldest entries again. Issue decisions appear as one-cycle pulses, registered one cycle after the decision. A wrapping counter totals the issued instructions so that throughput can be measured.

Top module: `pair_issue_unit`

## Requirements
- R1: A synchronous active-high `rst` empties the window and clears the remaining-stall count, both issue pulses and the issued-instruction counter. After reset no held instruction issues.
- R2: Each issue decision gives a one-cycle pulse on `issue0` (older) and/or `issue1` (younger) in the cycle after the decision. `issue1` is never high without `issue0`.
- R3: Two instructions of the same group issue one at a time, with the older first. This holds for EX (code 0), LS (code 1) and BR (code 2). Two MT instructions (code 3) may pair.
- R4: When the older instruction issues alone and the younger slot is valid, `recomb` is high in that cycle. The younger instruction becomes the older one, and the younger slot takes the first fetched instruction.
- R5: Instructions of different groups among EX, LS, BR and MT issue together in one cycle when no other rule forbids it.
- R6: An instruction of group CO (code 4), of the non-parallel group (code 5) or of an unused code (6, 7) never pairs, in either slot.
- R7: If the older slot writes a register (`f_wr`=1) whose index equals either source index of the younger slot, the two do not pair. The destination index is ignored when `f_wr`=0.
- R8: An older instruction with the lock flag set issues alone. The younger one waits until the lock's issue cycles have ended and then issues, paired with the next instruction when the rules allow.
- R9: An instruction with step count S ≥ 2 issues alone and occupies S issue cycles. No instruction issues in the S−1 cycles that follow, and `stall_cnt` reports the remaining stall cycles, counting down by one each cycle. Step counts 0 and 1 mean a single cycle.
- R10: A multi-step instruction in the younger slot does not pair. It issues later from the older slot.
- R11: `issued_total` adds the number of instructions issued in each cycle and wraps modulo 2^CNT_W (8 bits by default).
- R12: `fetch_pop` gives the number of fetched instructions consumed in the current cycle. It is 2 when the window empties and both fetch slots are valid, 1 when one instruction is recombined, and 0 while the window stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_vld0 | input | 1 | First fetched instruction is valid |
| f_grp0 | input | 3 | Group code of first fetched instruction |
| f_srca0 | input | RW | Source register A index, first fetched |
| f_srcb0 | input | RW | Source register B index, first fetched |
| f_dst0 | input | RW | Destination register index, first fetched |
| f_wr0 | input | 1 | First fetched instruction writes `f_dst0` |
| f_lock0 | input | 1 | First fetched instruction takes a resource lock |
| f_steps0 | input | SW | Issue-cycle count, first fetched |
| f_vld1 | input | 1 | Second fetched instruction is valid (only with `f_vld0`) |
| f_grp1 | input | 3 | Group code of second fetched instruction |
| f_srca1 | input | RW | Source register A index, second fetched |
| f_srcb1 | input | RW | Source register B index, second fetched |
| f_dst1 | input | RW | Destination register index, second fetched |
| f_wr1 | input | 1 | Second fetched instruction writes `f_dst1` |
| f_lock1 | input | 1 | Second fetched instruction takes a resource lock |
| f_steps1 | input | SW | Issue-cycle count, second fetched |
| fetch_pop | output | 2 | Fetched instructions consumed this cycle |
| recomb | output | 1 | Younger instruction is carried into the next pair this cycle |
| issue0 | output | 1 | Registered pulse: older slot issued |
| issue1 | output | 1 | Registered pulse: younger slot issued |
| stall_cnt | output | SW | Remaining stall cycles of a multi-step instruction |
| issued_total | output | CNT_W | Wrapping count of issued instructions |

## Verification
The hardest state to reach is a held younger instruction, left behind by a locked or multi-step older one, that survives several stall cycles and must then pair with a new arrival, with no further fetch in the meantime. The bench models a fetch queue that pops exactly what `fetch_pop` reports. A three-entry queue puts a locked four-step LS instruction ahead of an EX and an LS. The bench then checks that the pair issues together only on the cycle after the countdown reaches zero. A long stream of EX/LS pairs drives the counter through its wrap.

// File: rtl/pairing_pkg.sv
package pairing_pkg;
  localparam logic [2:0] GRP_EX = 3'd0;
  localparam logic [2:0] GRP_LS = 3'd1;
  localparam logic [2:0] GRP_BR = 3'd2;
  localparam logic [2:0] GRP_MT = 3'd3;
  localparam logic [2:0] GRP_CO = 3'd4;
  localparam logic [2:0] GRP_NP = 3'd5;

  // Groups that may never share an issue cycle with anything.
  function automatic logic grp_solo(input logic [2:0] g);
    return (g >= GRP_CO);
  endfunction

  // Two parallel-capable instructions of one unit collide; MT is duplicated.
  function automatic logic grp_collide(input logic [2:0] a, input logic [2:0] b);
    return (a == b) && (a != GRP_MT);
  endfunction
endpackage

// File: rtl/pair_rules.sv
module pair_rules
  import pairing_pkg::*;
#(
  parameter int RW = 4,
  parameter int SW = 3,
  localparam int IW = SW + 5 + 3 * RW
) (
  input  logic          v0,
  input  logic [IW-1:0] i0,
  input  logic          v1,
  input  logic [IW-1:0] i1,
  output logic          pair_ok,
  output logic [SW-1:0] steps0
);
  localparam int O_LOCK = SW;
  localparam int O_WR   = SW + 1;
  localparam int O_DST  = SW + 2;
  localparam int O_SRCB = SW + 2 + RW;
  localparam int O_SRCA = SW + 2 + 2 * RW;
  localparam int O_GRP  = SW + 2 + 3 * RW;

  logic [2:0]    g0, g1;
  logic [RW-1:0] dst0, sa1, sb1;
  logic [SW-1:0] steps1;
  logic          wr0, lock0;
  logic          raw_hazard, multi0, multi1, unit_clash, any_solo;

  always_comb begin
    g0     = i0[O_GRP +: 3];
    g1     = i1[O_GRP +: 3];
    dst0   = i0[O_DST +: RW];
    wr0    = i0[O_WR];
    lock0  = i0[O_LOCK];
    steps0 = i0[SW-1:0];
    sa1    = i1[O_SRCA +: RW];
    sb1    = i1[O_SRCB +: RW];
    steps1 = i1[SW-1:0];

    raw_hazard = wr0 && ((dst0 == sa1) || (dst0 == sb1));
    multi0     = steps0 > SW'(1);
    multi1     = steps1 > SW'(1);
    unit_clash = grp_collide(g0, g1);
    any_solo   = grp_solo(g0) || grp_solo(g1);

    pair_ok = v0 && v1 && !any_solo && !unit_clash && !raw_hazard
              && !lock0 && !multi0 && !multi1;
  end
endmodule

// File: rtl/issue_window.sv
module issue_window #(
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fv0,
  input  logic [IW-1:0] f0,
  input  logic          fv1,
  input  logic [IW-1:0] f1,
  input  logic          busy,
  input  logic          iss0,
  input  logic          iss1,
  output logic          wv0,
  output logic [IW-1:0] w0,
  output logic          wv1,
  output logic [IW-1:0] w1,
  output logic [1:0]    pop,
  output logic          recomb
);
  logic          nv0, nv1;
  logic [IW-1:0] n0, n1;
  logic [1:0]    left;
  logic [IW-1:0] left0;

  always_comb begin
    // Instructions that remain in the window after this cycle's decision.
    if (busy) begin
      left  = {1'b0, wv0} + {1'b0, wv1};
      left0 = w0;
    end else if (iss1 || !wv0) begin
      left  = 2'd0;
      left0 = w0;
    end else begin
      left  = {1'b0, wv1};
      left0 = w1;
    end

    recomb = iss0 && !iss1 && wv1;

    n0  = w0;
    n1  = w1;
    nv0 = wv0;
    nv1 = wv1;
    pop = 2'd0;
    case (left)
      2'd2: ;
      2'd1: begin
        n0  = left0;
        nv0 = 1'b1;
        n1  = f0;
        nv1 = fv0;
        pop = {1'b0, fv0};
      end
      default: begin
        n0  = f0;
        nv0 = fv0;
        n1  = f1;
        nv1 = fv0 && fv1;
        pop = {1'b0, fv0} + {1'b0, fv0 && fv1};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wv0 <= 1'b0;
      wv1 <= 1'b0;
      w0  <= '0;
      w1  <= '0;
    end else begin
      wv0 <= nv0;
      wv1 <= nv1;
      w0  <= n0;
      w1  <= n1;
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] steps,
  output logic [SW-1:0] remain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (remain != '0) begin
      remain <= remain - SW'(1);
    end else if (start && (steps > SW'(1))) begin
      remain <= steps - SW'(1);
    end
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit #(
  parameter int RW    = 4,
  parameter int SW    = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             f_vld0,
  input  logic [2:0]       f_grp0,
  input  logic [RW-1:0]    f_srca0,
  input  logic [RW-1:0]    f_srcb0,
  input  logic [RW-1:0]    f_dst0,
  input  logic             f_wr0,
  input  logic             f_lock0,
  input  logic [SW-1:0]    f_steps0,
  input  logic             f_vld1,
  input  logic [2:0]       f_grp1,
  input  logic [RW-1:0]    f_srca1,
  input  logic [RW-1:0]    f_srcb1,
  input  logic [RW-1:0]    f_dst1,
  input  logic             f_wr1,
  input  logic             f_lock1,
  input  logic [SW-1:0]    f_steps1,
  output logic [1:0]       fetch_pop,
  output logic             recomb,
  output logic             issue0,
  output logic             issue1,
  output logic [SW-1:0]    stall_cnt,
  output logic [CNT_W-1:0] issued_total
);
  localparam int IW = SW + 5 + 3 * RW;

  logic [IW-1:0] fpk0, fpk1, w0, w1;
  logic          wv0, wv1, pair_ok, busy, iss0, iss1;
  logic [SW-1:0] steps0;

  // Field packing: group, srcA, srcB, dst, write, lock, steps (LSBs).
  assign fpk0 = {f_grp0, f_srca0, f_srcb0, f_dst0, f_wr0, f_lock0, f_steps0};
  assign fpk1 = {f_grp1, f_srca1, f_srcb1, f_dst1, f_wr1, f_lock1, f_steps1};

  pair_rules #(.RW(RW), .SW(SW)) u_rules (
    .v0(wv0), .i0(w0), .v1(wv1), .i1(w1),
    .pair_ok(pair_ok), .steps0(steps0)
  );

  assign busy = (stall_cnt != '0);
  assign iss0 = wv0 && !busy;
  assign iss1 = iss0 && pair_ok;

  issue_window #(.IW(IW)) u_window (
    .clk(clk), .rst(rst),
    .fv0(f_vld0), .f0(fpk0), .fv1(f_vld1), .f1(fpk1),
    .busy(busy), .iss0(iss0), .iss1(iss1),
    .wv0(wv0), .w0(w0), .wv1(wv1), .w1(w1),
    .pop(fetch_pop), .recomb(recomb)
  );

  busy_timer #(.SW(SW)) u_busy (
    .clk(clk), .rst(rst), .start(iss0), .steps(steps0), .remain(stall_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue0       <= 1'b0;
      issue1       <= 1'b0;
      issued_total <= '0;
    end else begin
      issue0       <= iss0;
      issue1       <= iss1;
      issued_total <= issued_total + CNT_W'(iss0) + CNT_W'(iss1);
    end
  end
endmodule

// File: rtl/pairing_checker.sv
module pairing_checker #(
  parameter int SW    = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       fetch_pop,
  input logic             recomb,
  input logic             issue0,
  input logic             issue1,
  input logic [SW-1:0]    stall_cnt,
  input logic [CNT_W-1:0] issued_total
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stall_cnt == '0 && !issue0 && !issue1 && issued_total == '0)); // R1

  AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (rst)
    issue1 |-> issue0); // R2

  AST_RECOMB_SOLO: assert property (@(posedge clk) disable iff (rst)
    recomb |=> (issue0 && !issue1)); // R4

  AST_RECOMB_POP: assert property (@(posedge clk) disable iff (rst)
    recomb |-> (fetch_pop != 2'd2)); // R12

  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt != '0) |=> (!issue0 && !issue1)); // R9

  AST_STALL_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (stall_cnt != '0) |=> (stall_cnt == $past(stall_cnt) - SW'(1))); // R9

  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (issued_total ==
              CNT_W'($past(issued_total) + CNT_W'(issue0) + CNT_W'(issue1)))); // R11
endmodule

bind pair_issue_unit pairing_checker #(.SW(SW), .CNT_W(CNT_W)) u_pairing_checker (
  .clk(clk), .rst(rst), .fetch_pop(fetch_pop), .recomb(recomb),
  .issue0(issue0), .issue1(issue1), .stall_cnt(stall_cnt),
  .issued_total(issued_total)
);

// File: tb/test_pair_issue_unit.sv
module test_pair_issue_unit;
  localparam int RW = 4;
  localparam int SW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          f_vld0, f_vld1, f_wr0, f_wr1, f_lock0, f_lock1;
  logic [2:0]    f_grp0, f_grp1;
  logic [RW-1:0] f_srca0, f_srcb0, f_dst0, f_srca1, f_srcb1, f_dst1;
  logic [SW-1:0] f_steps0, f_steps1;
  logic [1:0]    fetch_pop;
  logic          recomb, issue0, issue1;
  logic [SW-1:0] stall_cnt;
  logic [CW-1:0] issued_total;

  pair_issue_unit #(.RW(RW), .SW(SW), .CNT_W(CW)) i_pair_issue_unit (
    .clk(clk), .rst(rst),
    .f_vld0(f_vld0), .f_grp0(f_grp0), .f_srca0(f_srca0), .f_srcb0(f_srcb0),
    .f_dst0(f_dst0), .f_wr0(f_wr0), .f_lock0(f_lock0), .f_steps0(f_steps0),
    .f_vld1(f_vld1), .f_grp1(f_grp1), .f_srca1(f_srca1), .f_srcb1(f_srcb1),
    .f_dst1(f_dst1), .f_wr1(f_wr1), .f_lock1(f_lock1), .f_steps1(f_steps1),
    .fetch_pop(fetch_pop), .recomb(recomb), .issue0(issue0), .issue1(issue1),
    .stall_cnt(stall_cnt), .issued_total(issued_total)
  );

  int checks = 0;
  int errors = 0;

  // Fetch queue model
  logic [2:0]    q_grp [0:15];
  logic [RW-1:0] q_sa [0:15], q_sb [0:15], q_dst [0:15];
  logic          q_wr [0:15], q_lk [0:15];
  logic [SW-1:0] q_st [0:15];
  int qn = 0, qh = 0, k = 0;
  bit stream = 1'b0;

  // Observations per step
  logic          o_i0 [0:255], o_i1 [0:255], o_rc [0:255];
  logic [1:0]    o_pop [0:255];
  logic [SW-1:0] o_st [0:255];
  logic [CW-1:0] o_tot [0:255];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic push(input logic [2:0] g, input int sa, input int sb, input int d,
                      input bit wr, input bit lk, input int st);
    q_grp[qn] = g; q_sa[qn] = RW'(sa); q_sb[qn] = RW'(sb); q_dst[qn] = RW'(d);
    q_wr[qn] = wr; q_lk[qn] = lk; q_st[qn] = SW'(st);
    qn++;
  endtask

  task automatic idle_inputs();
    f_vld0 = 0; f_vld1 = 0; f_grp0 = 0; f_grp1 = 0; f_wr0 = 0; f_wr1 = 0;
    f_lock0 = 0; f_lock1 = 0; f_srca0 = 0; f_srcb0 = 0; f_dst0 = 0;
    f_srca1 = 0; f_srcb1 = 0; f_dst1 = 0; f_steps0 = 0; f_steps1 = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    qn = 0; qh = 0; k = 0; stream = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    if (stream) begin
      f_vld0 = 1; f_grp0 = 3'd0; f_srca0 = 5; f_srcb0 = 6; f_dst0 = 1; f_wr0 = 1;
      f_lock0 = 0; f_steps0 = 1;
      f_vld1 = 1; f_grp1 = 3'd1; f_srca1 = 7; f_srcb1 = 8; f_dst1 = 2; f_wr1 = 1;
      f_lock1 = 0; f_steps1 = 1;
    end else begin
      f_vld0 = (qh < qn);
      f_vld1 = (qh + 1 < qn);
      if (qh < qn) begin
        f_grp0 = q_grp[qh]; f_srca0 = q_sa[qh]; f_srcb0 = q_sb[qh]; f_dst0 = q_dst[qh];
        f_wr0 = q_wr[qh]; f_lock0 = q_lk[qh]; f_steps0 = q_st[qh];
      end
      if (qh + 1 < qn) begin
        f_grp1 = q_grp[qh+1]; f_srca1 = q_sa[qh+1]; f_srcb1 = q_sb[qh+1];
        f_dst1 = q_dst[qh+1]; f_wr1 = q_wr[qh+1]; f_lock1 = q_lk[qh+1];
        f_steps1 = q_st[qh+1];
      end
    end
    #1;
    o_i0[k] = issue0; o_i1[k] = issue1; o_rc[k] = recomb; o_pop[k] = fetch_pop;
    o_st[k] = stall_cnt; o_tot[k] = issued_total;
    if (!stream) qh += int'(fetch_pop);
    k++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int pat(input int s);
    return {o_i0[s], o_i1[s]};
  endfunction

  task automatic t_reset();
    do_reset();
    steps(2);
    chk_eq("R1", "issue0 after reset", o_i0[0], 0);
    chk_eq("R1", "issue1 after reset", o_i1[0], 0);
    chk_eq("R1", "stall after reset", o_st[0], 0);
    chk_eq("R1", "total after reset", o_tot[0], 0);
    chk_eq("R12", "pop with empty fetch", o_pop[1], 0);
  endtask

  task automatic t_ex_ex_chain();
    do_reset();
    push(3'd0, 5, 6, 1, 1, 0, 1);
    push(3'd0, 7, 8, 2, 1, 0, 1);
    push(3'd0, 9, 10, 3, 1, 0, 1);
    push(3'd1, 11, 12, 4, 1, 0, 1);
    steps(5);
    chk_eq("R12", "pop of two into empty window", o_pop[0], 2);
    chk_eq("R4", "recomb on EX/EX", o_rc[1], 1);
    chk_eq("R12", "pop on recombine", o_pop[1], 1);
    chk_eq("R3", "EX/EX first issues alone", pat(2), 2);
    chk_eq("R3", "held EX vs next EX alone", pat(3), 2);
    chk_eq("R5", "recombined EX pairs with LS", pat(4), 3);
    chk_eq("R2", "no issue before decision", pat(1), 0);
    chk_eq("R11", "total after chain", o_tot[4], 4);
  endtask

  task automatic pair_case(input string req, input logic [2:0] g0, input logic [2:0] g1,
                           input bit wr0, input int dst0, input int sa1, input int sb1,
                           input bit expect_pair);
    do_reset();
    push(g0, 5, 6, dst0, wr0, 0, 1);
    push(g1, sa1, sb1, 9, 1, 0, 1);
    steps(4);
    chk_eq(req, $sformatf("grp %0d/%0d decision", g0, g1), pat(2), expect_pair ? 3 : 2);
    if (!expect_pair) chk_eq("R4", "held younger issues next", pat(3), 2);
  endtask

  task automatic t_multistep();
    do_reset();
    push(3'd1, 5, 6, 1, 1, 0, 4);
    push(3'd0, 7, 8, 2, 1, 0, 1);
    push(3'd0, 9, 10, 3, 1, 0, 1);
    steps(7);
    chk_eq("R9", "multi-step issues alone", pat(2), 2);
    chk_eq("R9", "stall count start", o_st[2], 3);
    chk_eq("R9", "stall count down", o_st[3], 2);
    chk_eq("R9", "no issue while stalled", pat(4), 0);
    chk_eq("R9", "stall at zero", o_st[5], 0);
    chk_eq("R9", "last stall cycle idle", pat(5), 0);
    chk_eq("R12", "no pop with full window", o_pop[2], 0);
    chk_eq("R9", "next issue after four cycles", pat(6), 2);
  endtask

  task automatic t_lock();
    do_reset();
    push(3'd1, 5, 6, 1, 1, 1, 4);
    push(3'd0, 7, 8, 2, 1, 0, 1);
    push(3'd1, 9, 10, 3, 1, 0, 1);
    steps(7);
    chk_eq("R8", "locked older alone", pat(2), 2);
    chk_eq("R8", "held during lock", pat(5), 0);
    chk_eq("R8", "held pairs with next after lock", pat(6), 3);
    do_reset();
    push(3'd1, 5, 6, 1, 1, 1, 1);
    push(3'd0, 7, 8, 2, 1, 0, 1);
    steps(4);
    chk_eq("R8", "single-cycle lock still alone", pat(2), 2);
    chk_eq("R8", "younger follows lock", pat(3), 2);
  endtask

  task automatic t_young_multi();
    do_reset();
    push(3'd0, 5, 6, 1, 1, 0, 1);
    push(3'd1, 7, 8, 2, 1, 0, 2);
    steps(5);
    chk_eq("R10", "younger multi-step not paired", pat(2), 2);
    chk_eq("R10", "multi-step issues from older slot", pat(3), 2);
    chk_eq("R10", "stall after younger multi", o_st[3], 1);
    chk_eq("R10", "idle during its stall", pat(4), 0);
  endtask

  task automatic t_reset_mid();
    do_reset();
    push(3'd1, 5, 6, 1, 1, 0, 5);
    push(3'd0, 7, 8, 2, 1, 0, 1);
    steps(3);
    chk_eq("R9", "stall before reset", o_st[2], 4);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk_eq("R1", "stall cleared mid-run", int'(stall_cnt), 0);
    chk_eq("R1", "total cleared mid-run", int'(issued_total), 0);
    qh = qn; k = 0;
    steps(3);
    chk_eq("R1", "held instruction dropped", pat(1) + pat(2), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    stream = 1'b1;
    steps(132);
    chk_eq("R5", "stream pairs EX/LS", pat(10), 3);
    chk_eq("R11", "total before wrap", o_tot[128], 254);
    chk_eq("R11", "total wraps to zero", o_tot[129], 0);
    chk_eq("R11", "total after wrap", o_tot[131], 4);
    stream = 1'b0;
  endtask

  initial begin
    idle_inputs();
    t_reset();
    t_ex_ex_chain();
    pair_case("R3", 3'd1, 3'd1, 1, 1, 2, 3, 0);
    pair_case("R3", 3'd2, 3'd2, 1, 1, 2, 3, 0);
    pair_case("R3", 3'd3, 3'd3, 1, 1, 2, 3, 1);
    pair_case("R5", 3'd1, 3'd0, 1, 1, 2, 3, 1);
    pair_case("R5", 3'd2, 3'd3, 1, 1, 2, 3, 1);
    pair_case("R6", 3'd4, 3'd0, 1, 1, 2, 3, 0);
    pair_case("R6", 3'd0, 3'd4, 1, 1, 2, 3, 0);
    pair_case("R6", 3'd5, 3'd1, 1, 1, 2, 3, 0);
    pair_case("R6", 3'd1, 3'd7, 1, 1, 2, 3, 0);
    pair_case("R7", 3'd0, 3'd1, 1, 4, 4, 3, 0);
    pair_case("R7", 3'd0, 3'd1, 1, 4, 2, 4, 0);
    pair_case("R7", 3'd0, 3'd1, 0, 4, 4, 4, 1);
    t_multistep();
    t_lock();
    t_young_multi();
    t_reset_mid();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule